// File: doc/BRIEF.md
# Multi-Page-Size Address Translation Cache

This block is a small fully associative cache of address translations. It turns a 32-bit virtual address into a 32-bit physical address. Each of its entries maps one page, and the page can be 4 KB, 64 KB, 1 MB or 16 MB. A 2-bit size code stored in the entry sets how many of the upper address bits take part in the tag compare, and how many lower bits pass through to the physical address unchanged.

A lookup request on the request stream is compared against every entry in the same cycle. The response is registered and comes out one cycle later. It reports a hit with a physical address, a permission fault, or a miss. Entries are written through a refill port into the slot chosen by a round-robin pointer. An invalidate-all pulse empties the cache.

Request flow rules: `req_ready` is held high at all times, so the block never applies back-pressure. A request is accepted on every clock edge where `req_valid` is high. The response stream has no ready input. Each response is a single-cycle pulse that the requester must take when it appears.

Top module: `pgx_xlat`

## Requirements
- R1: `req_ready` is always 1. A request accepted at edge N gives `rsp_valid`=1 for exactly the cycle after edge N. When no request was accepted, `rsp_valid`, `rsp_hit` and `rsp_fault` are 0.
- R2: An entry's size code selects the compared tag bits. Code 0 (4 KB) compares virtual bits 31:12. Code 1 (64 KB) compares bits 31:16. Code 2 (1 MB) compares bits 31:20. Code 3 (16 MB) compares bits 31:24.
- R3: On a hit, the physical address takes its upper bits from the entry frame (the same bits as the compared field). The remaining low offset bits are copied from the request address. The frame's low bits are ignored.
- R4: A request that matches no valid entry returns `rsp_hit`=0, `rsp_fault`=0 and `rsp_paddr`=0.
- R5: A read (`req_write`=0) needs the entry's read permit, and a write (`req_write`=1) needs its write permit. If the permit is missing, the response is `rsp_fault`=1, `rsp_hit`=0 and `rsp_paddr`=0.
- R6: When several valid entries match, only the lowest-indexed one decides the hit, the fault and the address.
- R7: Refills go to slots 0, 1, … 7 in turn and then wrap to 0. Each refill replaces the mapping that slot held before.
- R8: Invalidate-all clears every entry and sets the refill pointer back to slot 0. A refill in the same cycle is dropped.
- R9: A lookup in the same cycle as a refill sees the old contents. The new entry is visible to requests from the next cycle onward.
- R10: After reset, every entry is invalid, the refill pointer is at slot 0, and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Always 1; requests are never stalled |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response pulse, one cycle after an accepted request |
| rsp_hit | output | 1 | Translation found and access allowed |
| rsp_fault | output | 1 | Matching entry forbids this access type |
| rsp_paddr | output | 32 | Translated address on a hit, else 0 |
| fill_en | input | 1 | Write one entry at the round-robin slot |
| fill_vaddr | input | 32 | Virtual page address of the new entry |
| fill_paddr | input | 32 | Physical frame address of the new entry |
| fill_size | input | 2 | Page-size code (0=4 KB, 1=64 KB, 2=1 MB, 3=16 MB) |
| fill_rd | input | 1 | Read permit of the new entry |
| fill_wr | input | 1 | Write permit of the new entry |
| inv_all | input | 1 | Invalidate every entry |

## Verification
Each lookup result is due one clock edge after the request is accepted, so the bench drives a request on a falling edge and reads the response on the next falling edge. Refills and invalidates take effect at the edge where they are sampled, so the first request that can see them is the one driven on the following falling edge. The bench keeps a shadow copy of the entries that is updated at the same points. For the same-cycle refill case, it works out the expected value before it updates that copy. One falling edge after a response, it checks that the pulse has ended.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int VA_W     = 32;
  localparam int OFF_BASE = 12;
  localparam int OFF_STEP = 4;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_1M  = 2'd2,
    PG_16M = 2'd3
  } pg_size_e;

  typedef struct packed {
    logic            vld;
    pg_size_e        size;
    logic            rd;
    logic            wr;
    logic [VA_W-1:0] vtag;
    logic [VA_W-1:0] frame;
  } ent_t;

  function automatic logic [VA_W-1:0] off_mask(input pg_size_e s);
    logic [VA_W-1:0] m;
    int lim;
    lim = OFF_BASE + OFF_STEP * int'(s);
    m = '0;
    for (int b = 0; b < VA_W; b++) begin
      if (b < lim) m[b] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/pgx_match.sv
module pgx_match #(
  parameter int NUM_ENT = 8
) (
  input  pgx_pkg::ent_t [NUM_ENT-1:0]  ents,
  input  logic [pgx_pkg::VA_W-1:0]     vaddr,
  output logic [NUM_ENT-1:0]           hit_vec
);
  import pgx_pkg::*;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    logic [VA_W-1:0] keep;
    assign keep       = ~off_mask(ents[g].size);
    assign hit_vec[g] = ents[g].vld && ((vaddr & keep) == (ents[g].vtag & keep));
  end
endmodule

// File: rtl/pgx_pick.sv
module pgx_pick #(
  parameter int NUM_ENT = 8,
  localparam int IW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic [NUM_ENT-1:0] vec,
  output logic               found,
  output logic [IW-1:0]      idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pgx_store.sv
module pgx_store #(
  parameter int NUM_ENT = 8,
  localparam int IW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fill_en,
  input  pgx_pkg::ent_t               fill_ent,
  input  logic                        inv_all,
  output pgx_pkg::ent_t [NUM_ENT-1:0] ents
);
  import pgx_pkg::*;

  logic [IW-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (inv_all) begin
      ptr_q <= '0;
    end else if (fill_en) begin
      ptr_q <= (ptr_q == IW'(NUM_ENT - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ents[g] <= '0;
      end else if (inv_all) begin
        ents[g].vld <= 1'b0;
      end else if (fill_en && ptr_q == IW'(g)) begin
        ents[g] <= fill_ent;
      end
    end
  end
endmodule

// File: rtl/pgx_xlat.sv
module pgx_xlat #(
  parameter int NUM_ENT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  output logic        rsp_valid,
  output logic        rsp_hit,
  output logic        rsp_fault,
  output logic [31:0] rsp_paddr,
  input  logic        fill_en,
  input  logic [31:0] fill_vaddr,
  input  logic [31:0] fill_paddr,
  input  logic [1:0]  fill_size,
  input  logic        fill_rd,
  input  logic        fill_wr,
  input  logic        inv_all
);
  import pgx_pkg::*;
  localparam int IW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

  ent_t [NUM_ENT-1:0] ents;
  ent_t               new_ent;
  logic [NUM_ENT-1:0] hit_vec;
  logic               any_hit;
  logic [IW-1:0]      sel_idx;
  ent_t               sel;
  logic [VA_W-1:0]    sel_mask;
  logic               allowed;
  logic [VA_W-1:0]    merged;

  assign req_ready = 1'b1;

  always_comb begin
    new_ent       = '0;
    new_ent.vld   = 1'b1;
    new_ent.size  = pg_size_e'(fill_size);
    new_ent.rd    = fill_rd;
    new_ent.wr    = fill_wr;
    new_ent.vtag  = fill_vaddr;
    new_ent.frame = fill_paddr;
  end

  pgx_store #(.NUM_ENT(NUM_ENT)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .fill_en  (fill_en),
    .fill_ent (new_ent),
    .inv_all  (inv_all),
    .ents     (ents)
  );

  pgx_match #(.NUM_ENT(NUM_ENT)) u_match (
    .ents    (ents),
    .vaddr   (req_vaddr),
    .hit_vec (hit_vec)
  );

  pgx_pick #(.NUM_ENT(NUM_ENT)) u_pick (
    .vec   (hit_vec),
    .found (any_hit),
    .idx   (sel_idx)
  );

  assign sel      = ents[sel_idx];
  assign sel_mask = off_mask(sel.size);
  assign allowed  = req_write ? sel.wr : sel.rd;
  assign merged   = (sel.frame & ~sel_mask) | (req_vaddr & sel_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && any_hit && allowed;
      rsp_fault <= req_valid && any_hit && !allowed;
      rsp_paddr <= (req_valid && any_hit && allowed) ? merged : '0;
    end
  end
endmodule

// File: rtl/pgx_xlat_chk.sv
module pgx_xlat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_vaddr,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic        rsp_fault,
  input logic [31:0] rsp_paddr,
  input logic        inv_all
);
  a_r1_ready_high: assert property (@(posedge clk) disable iff (!rst_n) req_ready);

  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_fault));

  a_r5_hit_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_fault));

  a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_hit || rsp_paddr[11:0] == $past(req_vaddr[11:0])));

  a_r4_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> rsp_paddr == 32'h0);

  a_r8_empty_after_inv: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && !req_valid) ##1 req_valid |=> (!rsp_hit && !rsp_fault));
endmodule

bind pgx_xlat pgx_xlat_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_vaddr (req_vaddr),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_fault (rsp_fault),
  .rsp_paddr (rsp_paddr),
  .inv_all   (inv_all)
);

// File: tb/pgx_xlat_tb.sv
module pgx_xlat_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [31:0] rsp_paddr;
  logic        fill_en = 1'b0;
  logic [31:0] fill_vaddr = '0, fill_paddr = '0;
  logic [1:0]  fill_size = '0;
  logic        fill_rd = 1'b0, fill_wr = 1'b0;
  logic        inv_all = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pgx_xlat #(.NUM_ENT(8)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .fill_en(fill_en), .fill_vaddr(fill_vaddr), .fill_paddr(fill_paddr), .fill_size(fill_size),
    .fill_rd(fill_rd), .fill_wr(fill_wr), .inv_all(inv_all)
  );

  // shadow model
  logic [31:0] m_va [8];
  logic [31:0] m_pa [8];
  int          m_sz [8];
  bit          m_rd [8], m_wr [8], m_v [8];
  int          m_ptr = 0;

  function automatic logic [31:0] low_mask(input int s);
    return (32'h1 << (12 + 4 * s)) - 32'h1;
  endfunction

  task automatic check(input bit ok, input string tag, input string detail);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", tag, detail);
    end
  endtask

  task automatic expect_of(input logic [31:0] va, input bit w,
                           output bit eh, output bit ef, output logic [31:0] ep);
    eh = 0; ef = 0; ep = '0;
    for (int i = 0; i < 8; i++) begin
      if (m_v[i] && ((va & ~low_mask(m_sz[i])) == (m_va[i] & ~low_mask(m_sz[i])))) begin
        if (w ? m_wr[i] : m_rd[i]) begin
          eh = 1;
          ep = (m_pa[i] & ~low_mask(m_sz[i])) | (va & low_mask(m_sz[i]));
        end else begin
          ef = 1;
        end
        return;
      end
    end
  endtask

  task automatic compare(input string tag, input bit eh, input bit ef, input logic [31:0] ep);
    check(rsp_valid && rsp_hit == eh && rsp_fault == ef && rsp_paddr == ep, tag,
          $sformatf("actual v=%0b h=%0b f=%0b pa=%h expected v=1 h=%0b f=%0b pa=%h",
                    rsp_valid, rsp_hit, rsp_fault, rsp_paddr, eh, ef, ep));
  endtask

  task automatic look(input logic [31:0] va, input bit w, input string tag);
    bit eh, ef;
    logic [31:0] ep;
    expect_of(va, w, eh, ef, ep);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_write = w;
    @(negedge clk);
    req_valid = 0;
    compare(tag, eh, ef, ep);
  endtask

  task automatic model_fill(input logic [31:0] va, input logic [31:0] pa, input int s,
                            input bit r, input bit w);
    m_va[m_ptr] = va; m_pa[m_ptr] = pa; m_sz[m_ptr] = s;
    m_rd[m_ptr] = r; m_wr[m_ptr] = w; m_v[m_ptr] = 1;
    m_ptr = (m_ptr + 1) % 8;
  endtask

  task automatic drive_fill(input logic [31:0] va, input logic [31:0] pa, input int s,
                            input bit r, input bit w);
    fill_en = 1; fill_vaddr = va; fill_paddr = pa; fill_size = 2'(s);
    fill_rd = r; fill_wr = w;
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pa, input int s,
                      input bit r, input bit w);
    @(negedge clk);
    drive_fill(va, pa, s, r, w);
    @(negedge clk);
    fill_en = 0;
    model_fill(va, pa, s, r, w);
  endtask

  task automatic model_clear();
    for (int i = 0; i < 8; i++) m_v[i] = 0;
    m_ptr = 0;
  endtask

  task automatic invalidate();
    @(negedge clk);
    inv_all = 1;
    @(negedge clk);
    inv_all = 0;
    model_clear();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit eh, ef;
    logic [31:0] ep;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    check(!rsp_valid && !rsp_hit && !rsp_fault && req_ready, "R10",
          $sformatf("actual v=%0b h=%0b f=%0b rdy=%0b expected 0 0 0 1",
                    rsp_valid, rsp_hit, rsp_fault, req_ready));
    look(32'hDEAD_BEEF, 0, "R10");
    look(32'h0000_0000, 1, "R4");

    // R2 R3 R5: sweep every size and permit combination
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 4; p++) begin
        logic [31:0] va, pa, off;
        int ow;
        ow  = 12 + 4 * s;
        va  = 32'hA5C3_96E1 ^ (32'(s * 4 + p) << 26);
        pa  = 32'h3B7F_1D2C + 32'(p * 32'h0101_0101);
        off = 32'h5A5A_5A5A & low_mask(s);
        invalidate();
        fill(va, pa, s, p[0], p[1]);
        look((va & ~low_mask(s)) | off, 0, "R5");
        look((va & ~low_mask(s)) | off, 1, "R5");
        look(va ^ (32'h1 << ow), 0, "R2");
        look(va ^ (32'h1 << (ow - 1)), 0, "R3");
        look(va ^ 32'h8000_0000, 1, "R4");
        // R1: pulse ends one cycle later
        @(negedge clk);
        check(!rsp_valid && !rsp_hit && !rsp_fault, "R1",
              $sformatf("actual v=%0b expected 0", rsp_valid));
      end
    end

    // R6: lowest index wins
    invalidate();
    fill(32'h8000_0000, 32'h0100_0FFF, 3, 1, 0);
    fill(32'h8012_3000, 32'h7777_7000, 0, 1, 1);
    look(32'h8012_3456, 1, "R6");
    look(32'h8012_3456, 0, "R6");
    invalidate();
    fill(32'h8012_3000, 32'h7777_7000, 0, 1, 1);
    fill(32'h8000_0000, 32'h0100_0000, 3, 1, 0);
    look(32'h8012_3456, 1, "R6");
    look(32'h8055_0004, 1, "R6");

    // R7: round-robin replacement with wrap
    invalidate();
    for (int i = 0; i < 8; i++) fill(32'h4000_0000 + 32'(i << 12), 32'h1000_0000 + 32'(i << 16), 0, 1, 1);
    for (int i = 0; i < 8; i++) look(32'h4000_0010 + 32'(i << 12), 0, "R7");
    fill(32'h5000_0000, 32'h2000_0000, 1, 1, 1);
    look(32'h4000_0010, 0, "R7");
    look(32'h4000_1010, 0, "R7");
    look(32'h5000_ABCD, 0, "R7");
    fill(32'h6000_0000, 32'h2100_0000, 2, 1, 1);
    look(32'h4000_1010, 0, "R7");

    // R8: invalidate beats a concurrent fill, pointer back to 0
    fill(32'h7000_0000, 32'h0300_0000, 0, 1, 1);
    @(negedge clk);
    inv_all = 1;
    drive_fill(32'h7100_0000, 32'h0400_0000, 0, 1, 1);
    @(negedge clk);
    inv_all = 0; fill_en = 0;
    model_clear();
    look(32'h7000_0000, 0, "R8");
    look(32'h7100_0000, 0, "R8");
    look(32'h4000_2010, 0, "R8");
    for (int i = 0; i < 9; i++) fill(32'h9000_0000 + 32'(i << 16), 32'h0C00_0000 + 32'(i << 16), 1, 1, 1);
    look(32'h9000_0123, 0, "R8");
    look(32'h9001_0123, 0, "R8");
    look(32'h9008_0123, 0, "R8");

    // R9: lookup in the same cycle as a fill sees old contents
    invalidate();
    expect_of(32'hC000_1234, 0, eh, ef, ep);
    @(negedge clk);
    drive_fill(32'hC000_0000, 32'hE000_0000, 1, 1, 1);
    req_valid = 1; req_vaddr = 32'hC000_1234; req_write = 0;
    @(negedge clk);
    fill_en = 0; req_valid = 0;
    model_fill(32'hC000_0000, 32'hE000_0000, 1, 1, 1);
    compare("R9", eh, ef, ep);
    look(32'hC000_1234, 0, "R9");

    // R1: back-to-back requests each give a response
    @(negedge clk);
    req_valid = 1; req_vaddr = 32'hC000_0001; req_write = 0;
    @(negedge clk);
    check(rsp_valid && rsp_hit && rsp_paddr == 32'hE000_0001, "R1",
          $sformatf("actual v=%0b h=%0b pa=%h expected 1 1 e0000001", rsp_valid, rsp_hit, rsp_paddr));
    req_vaddr = 32'hC001_0001;
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid && !rsp_hit && !rsp_fault, "R1",
          $sformatf("actual v=%0b h=%0b f=%0b expected 1 0 0", rsp_valid, rsp_hit, rsp_fault));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule